// File: doc/BRIEF.md
# Status-Decoded Bus Command Generator

This block sits beside a processor that reports each bus cycle only as a 3-bit status code, and turns that code into separate bus control signals. It samples the status lines on every clock. The first edge that sees a non-passive code after a passive one opens a cycle. The block then emits a one-clock address latch pulse and, after a configurable lag, the one command strobe that matches the cycle type. Data enable and transceiver direction follow the command. The cycle closes on the first edge that sees the passive code again.

The cycle type is captured when the cycle opens and held until it closes. A halt cycle produces the latch pulse and no command. A cycle that returns to passive before its command would start produces no command at all. All outputs are registered, so they come out of flops and do not glitch.

Top module: `bus_cmd_gen`

## Requirements
- R1: While `rst_n` is low, and until the first cycle opens, `ale_o`, `den_o` and `dtr_o` are 0 and all five active-low command outputs are 1.
- R2: When a clock edge samples a non-passive `stat_i` (anything but 3'b111) while no cycle is open, `ale_o` is 1 for exactly the following clock cycle.
- R3: The command strobe of the cycle goes low `CMD_LAG` clock cycles after `ale_o` rose. It stays low until an edge samples 3'b111, and it is never low while `ale_o` is 1.
- R4: The status decoding is: 3'b000 drives `inta_n_o`; 3'b001 drives `iord_n_o`; 3'b010 drives `iowr_n_o`; 3'b100 (code fetch) and 3'b101 both drive `mrd_n_o`; 3'b110 drives `mwr_n_o`.
- R5: Code 3'b011 (halt) gives the `ale_o` pulse but no command strobe and no `den_o`.
- R6: `dtr_o` is 1 for write cycles (3'b010, 3'b110) from the `ale_o` cycle through the end of the command. It is 0 for every other cycle type and while no cycle is open.
- R7: `den_o` is 1 exactly while one of the five command strobes is low.
- R8: The clock cycle after an edge that samples 3'b111 shows every output inactive. A cycle that returns to 3'b111 before its command time produces no command strobe.
- R9: The cycle type is taken from the code sampled at the opening edge. Later changes to other non-passive codes do not alter the strobe, `den_o` or `dtr_o` until the cycle closes.
- R10: A single edge that samples 3'b111 between two cycles is enough for the next non-passive code to open a new cycle with its own `ale_o` pulse.
- R11: At most one command strobe is low at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| stat_i | input | 3 | Encoded bus status from the processor; 3'b111 is passive |
| ale_o | output | 1 | Address latch enable, active high, one clock per cycle |
| den_o | output | 1 | Data transceiver enable, active high |
| dtr_o | output | 1 | Transceiver direction: 1 transmit (write), 0 receive |
| mrd_n_o | output | 1 | Memory read command, active low |
| mwr_n_o | output | 1 | Memory write command, active low |
| iord_n_o | output | 1 | IO read command, active low |
| iowr_n_o | output | 1 | IO write command, active low |
| inta_n_o | output | 1 | Interrupt acknowledge strobe, active low |

## Verification
The bench builds two copies that share one status input. One uses the default `CMD_LAG` of 1, the timing of a conventional bus. The other uses `CMD_LAG` of 3, which opens a two-clock setup window between the latch pulse and the command. Only with that window can a cycle that goes passive during setup be shown to produce no command, and only there are the counter's saturation and its reset between cycles exercised. Both copies are compared every clock against a timeline the bench computes from the code, the position in the cycle and the lag.

// File: rtl/bcg_pkg.sv
package bcg_pkg;

    localparam int STAT_W = 3;

    typedef enum logic [STAT_W-1:0] {
        ST_INTA  = 3'b000,
        ST_IORD  = 3'b001,
        ST_IOWR  = 3'b010,
        ST_HALT  = 3'b011,
        ST_FETCH = 3'b100,
        ST_MRD   = 3'b101,
        ST_MWR   = 3'b110,
        ST_PASV  = 3'b111
    } stat_code_e;

    typedef enum logic [2:0] {
        K_NONE,
        K_INTA,
        K_IORD,
        K_IOWR,
        K_MRD,
        K_MWR,
        K_HALT
    } cyc_kind_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_ADDR,
        PH_SETUP,
        PH_CMD
    } phase_e;

    typedef struct packed {
        logic ale;
        logic den;
        logic dtr;
        logic mrd_n;
        logic mwr_n;
        logic iord_n;
        logic iowr_n;
        logic inta_n;
    } bus_ctl_t;

    localparam bus_ctl_t CTL_IDLE = '{
        ale: 1'b0, den: 1'b0, dtr: 1'b0,
        mrd_n: 1'b1, mwr_n: 1'b1, iord_n: 1'b1, iowr_n: 1'b1, inta_n: 1'b1
    };

endpackage

// File: rtl/bcg_status_decode.sv
module bcg_status_decode
    import bcg_pkg::*;
(
    input  logic [STAT_W-1:0] stat_i,
    output cyc_kind_e         kind_o,
    output logic              passive_o
);

    always_comb begin
        passive_o = 1'b0;
        kind_o    = K_NONE;
        unique case (stat_code_e'(stat_i))
            ST_INTA:  kind_o = K_INTA;
            ST_IORD:  kind_o = K_IORD;
            ST_IOWR:  kind_o = K_IOWR;
            ST_HALT:  kind_o = K_HALT;
            ST_FETCH: kind_o = K_MRD;
            ST_MRD:   kind_o = K_MRD;
            ST_MWR:   kind_o = K_MWR;
            ST_PASV:  passive_o = 1'b1;
            default:  passive_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/bcg_cycle_fsm.sv
module bcg_cycle_fsm
    import bcg_pkg::*;
#(
    parameter int CMD_LAG = 1
) (
    input  logic      clk,
    input  logic      rst_n,
    input  cyc_kind_e kind_i,
    input  logic      passive_i,
    output phase_e    phase_d_o,
    output cyc_kind_e kind_d_o
);

    localparam int CNT_W = $clog2(CMD_LAG + 1);
    localparam logic [CNT_W-1:0] LAG_C = CNT_W'(CMD_LAG);

    typedef struct packed {
        phase_e          phase;
        cyc_kind_e       kind;
        logic [CNT_W-1:0] cnt;
    } fsm_t;

    fsm_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (!passive_i) begin
                    st_d.phase = PH_ADDR;
                    st_d.kind  = kind_i;
                    st_d.cnt   = CNT_W'(1);
                end
            end
            PH_ADDR, PH_SETUP: begin
                if (passive_i) begin
                    st_d.phase = PH_IDLE;
                    st_d.kind  = K_NONE;
                    st_d.cnt   = '0;
                end else if (st_q.cnt >= LAG_C) begin
                    st_d.phase = PH_CMD;
                end else begin
                    st_d.phase = PH_SETUP;
                    st_d.cnt   = st_q.cnt + CNT_W'(1);
                end
            end
            PH_CMD: begin
                if (passive_i) begin
                    st_d.phase = PH_IDLE;
                    st_d.kind  = K_NONE;
                    st_d.cnt   = '0;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, kind: K_NONE, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_d_o = st_d.phase;
    assign kind_d_o  = st_d.kind;

    // R8: a sampled passive code always closes the cycle
    assert_passive_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
        passive_i |=> (st_q.phase == PH_IDLE));

    // R9: the captured type holds while the cycle stays open
    assert_kind_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase != PH_IDLE && !passive_i) |=> $stable(st_q.kind));

    // R3: the command phase is reached only after the full lag
    assert_cmd_after_lag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_CMD) |-> (st_q.cnt == LAG_C));

    // R2: a non-passive code seen while idle opens the address phase
    assert_open_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_IDLE && !passive_i) |=> (st_q.phase == PH_ADDR));

endmodule

// File: rtl/bcg_strobe_gen.sv
module bcg_strobe_gen
    import bcg_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  phase_e    phase_i,
    input  cyc_kind_e kind_i,
    output bus_ctl_t  ctl_o
);

    bus_ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d     = CTL_IDLE;
        ctl_d.ale = (phase_i == PH_ADDR);
        ctl_d.dtr = (phase_i != PH_IDLE) && (kind_i == K_MWR || kind_i == K_IOWR);
        if (phase_i == PH_CMD) begin
            unique case (kind_i)
                K_INTA: begin ctl_d.inta_n = 1'b0; ctl_d.den = 1'b1; end
                K_IORD: begin ctl_d.iord_n = 1'b0; ctl_d.den = 1'b1; end
                K_IOWR: begin ctl_d.iowr_n = 1'b0; ctl_d.den = 1'b1; end
                K_MRD:  begin ctl_d.mrd_n  = 1'b0; ctl_d.den = 1'b1; end
                K_MWR:  begin ctl_d.mwr_n  = 1'b0; ctl_d.den = 1'b1; end
                default: ctl_d.den = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= CTL_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign ctl_o = ctl_q;

    logic [4:0] cmd_low;
    assign cmd_low = ~{ctl_q.mrd_n, ctl_q.mwr_n, ctl_q.iord_n, ctl_q.iowr_n, ctl_q.inta_n};

    // R2: the latch pulse lasts one clock
    assert_ale_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.ale |=> !ctl_q.ale);

    // R11: never more than one strobe low
    assert_one_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(cmd_low) <= 1);

    // R3: latch pulse and command never overlap
    assert_no_overlap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctl_q.ale && (cmd_low != 5'b0)));

    // R7: data enable only with an active strobe
    assert_den_with_cmd_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.den |-> (cmd_low != 5'b0));

    // R6: direction does not move while data is enabled
    assert_dtr_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.den && $past(ctl_q.den)) |-> $stable(ctl_q.dtr));

endmodule

// File: rtl/bus_cmd_gen.sv
module bus_cmd_gen
    import bcg_pkg::*;
#(
    parameter int CMD_LAG = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [STAT_W-1:0]   stat_i,
    output logic                ale_o,
    output logic                den_o,
    output logic                dtr_o,
    output logic                mrd_n_o,
    output logic                mwr_n_o,
    output logic                iord_n_o,
    output logic                iowr_n_o,
    output logic                inta_n_o
);

    cyc_kind_e dec_kind;
    logic      dec_passive;
    phase_e    nxt_phase;
    cyc_kind_e nxt_kind;
    bus_ctl_t  ctl;

    bcg_status_decode u_decode (
        .stat_i    (stat_i),
        .kind_o    (dec_kind),
        .passive_o (dec_passive)
    );

    bcg_cycle_fsm #(
        .CMD_LAG (CMD_LAG)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .kind_i    (dec_kind),
        .passive_i (dec_passive),
        .phase_d_o (nxt_phase),
        .kind_d_o  (nxt_kind)
    );

    bcg_strobe_gen u_strobe (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase_i (nxt_phase),
        .kind_i  (nxt_kind),
        .ctl_o   (ctl)
    );

    assign ale_o    = ctl.ale;
    assign den_o    = ctl.den;
    assign dtr_o    = ctl.dtr;
    assign mrd_n_o  = ctl.mrd_n;
    assign mwr_n_o  = ctl.mwr_n;
    assign iord_n_o = ctl.iord_n;
    assign iowr_n_o = ctl.iowr_n;
    assign inta_n_o = ctl.inta_n;

endmodule

// File: tb/bus_cmd_gen_bench.sv
module bus_cmd_gen_bench;

    localparam int LAG_A = 1;
    localparam int LAG_B = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] stat = 3'b111;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    logic a_ale, a_den, a_dtr, a_mrd, a_mwr, a_iord, a_iowr, a_inta;
    logic b_ale, b_den, b_dtr, b_mrd, b_mwr, b_iord, b_iowr, b_inta;

    bus_cmd_gen #(.CMD_LAG(LAG_A)) u_bus_cmd_gen (
        .clk(clk), .rst_n(rst_n), .stat_i(stat),
        .ale_o(a_ale), .den_o(a_den), .dtr_o(a_dtr), .mrd_n_o(a_mrd),
        .mwr_n_o(a_mwr), .iord_n_o(a_iord), .iowr_n_o(a_iowr), .inta_n_o(a_inta)
    );

    bus_cmd_gen #(.CMD_LAG(LAG_B)) u_bus_cmd_gen_lag3 (
        .clk(clk), .rst_n(rst_n), .stat_i(stat),
        .ale_o(b_ale), .den_o(b_den), .dtr_o(b_dtr), .mrd_n_o(b_mrd),
        .mwr_n_o(b_mwr), .iord_n_o(b_iord), .iowr_n_o(b_iowr), .inta_n_o(b_inta)
    );

    // order: ale den dtr mrd_n mwr_n iord_n iowr_n inta_n
    wire [7:0] act_a = {a_ale, a_den, a_dtr, a_mrd, a_mwr, a_iord, a_iowr, a_inta};
    wire [7:0] act_b = {b_ale, b_den, b_dtr, b_mrd, b_mwr, b_iord, b_iowr, b_inta};
    localparam logic [7:0] IDLE_V = 8'b0001_1111;

    // expected outputs at cycle position pos (1 = clock after opening edge)
    function automatic logic [7:0] expect_v(logic [2:0] code, int pos, int lag);
        logic [4:0] strb;
        logic       ale, den, dtr;
        strb = 5'b11111;
        ale  = (pos == 1);
        dtr  = (code == 3'b010) || (code == 3'b110);
        den  = 1'b0;
        if (pos > lag) begin
            case (code)
                3'b100, 3'b101: strb = 5'b01111;
                3'b110:         strb = 5'b10111;
                3'b001:         strb = 5'b11011;
                3'b010:         strb = 5'b11101;
                3'b000:         strb = 5'b11110;
                default:        strb = 5'b11111;
            endcase
            den = (strb != 5'b11111);
        end
        return {ale, den, dtr, strb};
    endfunction

    task automatic check_v(string req, string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b (ale den dtr mrd mwr iord iowr inta)",
                     req, tag, act, exp);
        end
    endtask

    // open a cycle with code, keep it non-passive for hold edges,
    // optionally switching to alt after position swap_at, then close it
    task automatic run_cycle(string req, logic [2:0] code, int hold,
                             logic [2:0] alt, int swap_at);
        stat = code;
        for (int i = 1; i <= hold; i++) begin
            @(posedge clk);
            @(negedge clk);
            check_v(req, "lag1", act_a, expect_v(code, i, LAG_A));
            check_v(req, "lag3", act_b, expect_v(code, i, LAG_B));
            if (i == swap_at) stat = alt;
        end
        stat = 3'b111;
        @(posedge clk);
        @(negedge clk);
        check_v({req, " close R8"}, "lag1", act_a, IDLE_V);
        check_v({req, " close R8"}, "lag3", act_b, IDLE_V);
    endtask

    task automatic t_reset;
        stat = 3'b101;
        repeat (3) @(negedge clk);
        check_v("R1 in reset", "lag1", act_a, IDLE_V);
        check_v("R1 in reset", "lag3", act_b, IDLE_V);
        stat = 3'b111;
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check_v("R1 after reset", "lag1", act_a, IDLE_V);
        check_v("R1 after reset", "lag3", act_b, IDLE_V);
    endtask

    task automatic t_all_codes;
        // R4 R3 R6 R7 R2: every non-passive, non-halt code
        logic [2:0] codes [6] = '{3'b000, 3'b001, 3'b010, 3'b100, 3'b101, 3'b110};
        foreach (codes[k]) run_cycle("R4 decode", codes[k], 5, codes[k], 0);
    endtask

    task automatic t_halt;
        run_cycle("R5 halt", 3'b011, 5, 3'b011, 0);
    endtask

    task automatic t_abort;
        // R8: passive before the command time; lag3 copy never strobes
        run_cycle("R8 abort after ale", 3'b101, 1, 3'b101, 0);
        run_cycle("R8 abort in setup", 3'b110, 2, 3'b110, 0);
        run_cycle("R8 abort at lag", 3'b001, 3, 3'b001, 0);
    endtask

    task automatic t_swap;
        run_cycle("R9 type held", 3'b101, 6, 3'b110, 2);
        run_cycle("R9 type held wr", 3'b010, 6, 3'b000, 1);
    endtask

    task automatic t_back_to_back;
        // R10: each cycle closes with a single passive edge
        run_cycle("R10 first", 3'b110, 4, 3'b110, 0);
        run_cycle("R10 second", 3'b001, 4, 3'b001, 0);
        run_cycle("R10 third", 3'b100, 4, 3'b100, 0);
    endtask

    task automatic t_long;
        run_cycle("R3 long hold", 3'b000, 24, 3'b000, 0);
    endtask

    task automatic t_exclusive;
        // R11: sample each position and count low strobes
        stat = 3'b010;
        for (int i = 1; i <= 5; i++) begin
            @(posedge clk);
            @(negedge clk);
            checks++;
            if ($countones(~act_a[4:0]) > 1 || $countones(~act_b[4:0]) > 1) begin
                errors++;
                $display("FAIL R11: actual %b/%b expected at most one low strobe",
                         act_a[4:0], act_b[4:0]);
            end
        end
        stat = 3'b111;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_all_codes();
        t_halt();
        t_abort();
        t_swap();
        t_back_to_back();
        t_long();
        t_exclusive();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule